// File: doc/BRIEF.md
# H-Bridge Gate Controller with Fault Latching

This block drives the four gates of one H-bridge leg pair: the two upper switches (U1, U2) and the two lower switches (L1, L2). In normal regulation it turns the chopper's present decay phase (charge, slow or fast) and the sign of the winding current into a gate pattern. In external-drive mode it skips regulation and switches the bridge straight from two drive inputs, one for each side of the load.

Several conditions force all four gates off. A low enable input turns the gates off but leaves the charge pump running. A low standby input, the all-zero drive mode code, an overcurrent detection and an over-temperature detection each turn the gates off and also stop the charge pump. An overcurrent is held in a latch that only a low-to-high transition on standby clears. The thermal condition is not latched. While it is present, a protect flag is raised.

Every output is registered. Each output reflects the inputs sampled at the previous rising clock edge, so any change of fault, enable or mode appears at the gates exactly one cycle later.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: In regulation mode with positive current (`dir_pos_i`=1), the registered gates {U1,U2,L1,L2} are 1001 for charge (`decay_i`=00), 0011 for slow (`decay_i`=01 or 11) and 0110 for fast (`decay_i`=10).
- R2: In regulation mode with negative current (`dir_pos_i`=0), the gates are 0110 for charge, 0011 for slow (01 or 11) and 1001 for fast.
- R3: A low `enable_i` forces all gates to 0 and leaves `pump_en_o` high. It clears no held state: a latched overcurrent stays latched, and the decoded pattern comes back in the cycle after enable returns high.
- R4: With `phase_mode_i`=1, the drive inputs {`gate_p_i`,`gate_n_i`} set the gates to 0110 for 01, to 1001 for 10, and to 0000 for 00 and 11. `decay_i` and `dir_pos_i` have no effect in this mode.
- R5: A low `standby_i` forces all gates and `pump_en_o` to 0.
- R6: `drive_mode_i`=000 acts exactly like a low standby. Any other code allows operation.
- R7: A high `ocp_det_i` latches an overcurrent fault. While the latch is set, the gates and `pump_en_o` are 0. The latch clears only in a cycle where `standby_i` is high, standby was low in the previous cycle, and `ocp_det_i` is low. Enable and mode changes do not clear it.
- R8: A high `otp_det_i` forces the gates and `pump_en_o` to 0 and drives `hot_flag_o` to 1. When the input drops, operation resumes with no latching.
- R9: Reset drives every output to 0. After reset, every output changes exactly one clock cycle after the input change that causes it.
- R10: U1 and L1 are never both on, and U2 and L2 are never both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | 1 = gates may switch; 0 = all gates off |
| standby_i | input | 1 | 1 = run; 0 = gates and charge pump off |
| drive_mode_i | input | 3 | Drive mode code; 000 acts as standby |
| phase_mode_i | input | 1 | 1 = external drive from gate_p_i/gate_n_i |
| dir_pos_i | input | 1 | Winding current sign, 1 = positive |
| decay_i | input | 2 | Chopper phase: 00 charge, 01/11 slow, 10 fast |
| gate_p_i | input | 1 | External drive, + side of the load |
| gate_n_i | input | 1 | External drive, - side of the load |
| ocp_det_i | input | 1 | Overcurrent detected |
| otp_det_i | input | 1 | Over-temperature detected |
| u1_o | output | 1 | Upper gate, leg 1 |
| u2_o | output | 1 | Upper gate, leg 2 |
| l1_o | output | 1 | Lower gate, leg 1 |
| l2_o | output | 1 | Lower gate, leg 2 |
| pump_en_o | output | 1 | Charge pump enable |
| hot_flag_o | output | 1 | Thermal protect flag |

## Verification
The only hidden state is the overcurrent latch and the previous-cycle standby sample. If the latch is set or cleared at the wrong time, `pump_en_o` and the gates differ from the expected values in the first cycle after the offending edge. The most likely causes are missing a standby rise, clearing on enable, or clearing while the detector is still high. A wrong decode table shows up in the cycle after a decay, direction or drive-input change, as a wrong gate pattern or as both switches of one leg turned on. The bench compares every output on every clock against a behavioural model, so a one-cycle latency slip is caught at once.

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       standby_i,
  input  logic [2:0] drive_mode_i,
  input  logic       phase_mode_i,
  input  logic       dir_pos_i,
  input  logic [1:0] decay_i,
  input  logic       gate_p_i,
  input  logic       gate_n_i,
  input  logic       ocp_det_i,
  input  logic       otp_det_i,
  output logic       u1_o,
  output logic       u2_o,
  output logic       l1_o,
  output logic       l2_o,
  output logic       pump_en_o,
  output logic       hot_flag_o
);

  // gate patterns, bit order {U1,U2,L1,L2}
  localparam logic [3:0] PAT_OFF   = 4'b0000;
  localparam logic [3:0] PAT_CROSS = 4'b1001;
  localparam logic [3:0] PAT_REV   = 4'b0110;
  localparam logic [3:0] PAT_BRAKE = 4'b0011;

  localparam logic [1:0] DEC_CHARGE = 2'b00;
  localparam logic [1:0] DEC_FAST   = 2'b10;

  logic       stby_q;
  logic       oc_lat;
  logic [3:0] gate_q;

  logic       stby_rise;
  logic       oc_nxt;
  logic       halt;
  logic       gates_off;
  logic [3:0] reg_pat;
  logic [3:0] ext_pat;
  logic [3:0] gate_nxt;

  assign stby_rise = standby_i & ~stby_q;
  assign oc_nxt    = ocp_det_i | (oc_lat & ~stby_rise);
  assign halt      = ~standby_i | (drive_mode_i == 3'b000) | oc_nxt | otp_det_i;
  assign gates_off = halt | ~enable_i;

  always_comb begin
    unique case (decay_i)
      DEC_CHARGE: reg_pat = dir_pos_i ? PAT_CROSS : PAT_REV;
      DEC_FAST:   reg_pat = dir_pos_i ? PAT_REV   : PAT_CROSS;
      default:    reg_pat = PAT_BRAKE;
    endcase
  end

  assign ext_pat  = (gate_p_i == gate_n_i) ? PAT_OFF :
                    (gate_p_i ? PAT_CROSS : PAT_REV);
  assign gate_nxt = gates_off ? PAT_OFF : (phase_mode_i ? ext_pat : reg_pat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q     <= 1'b0;
      oc_lat     <= 1'b0;
      gate_q     <= PAT_OFF;
      pump_en_o  <= 1'b0;
      hot_flag_o <= 1'b0;
    end else begin
      stby_q     <= standby_i;
      oc_lat     <= oc_nxt;
      gate_q     <= gate_nxt;
      pump_en_o  <= ~halt;
      hot_flag_o <= otp_det_i;
    end
  end

  assign {u1_o, u2_o, l1_o, l2_o} = gate_q;

  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(u1_o && l1_o) && !(u2_o && l2_o));

  // R3
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (gate_q == PAT_OFF));

  // R5
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_i |=> (gate_q == PAT_OFF && !pump_en_o));

  // R6
  mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_mode_i == 3'b000) |=> (gate_q == PAT_OFF && !pump_en_o));

  // R7
  oc_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_det_i |=> (oc_lat && gate_q == PAT_OFF && !pump_en_o));

  // R7
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat && !(standby_i && !stby_q)) |=> oc_lat);

  // R8
  thermal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_det_i |=> (hot_flag_o && !pump_en_o && gate_q == PAT_OFF));

  // R4
  ext_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_mode_i && gate_p_i && !gate_n_i && !gates_off) |=> (gate_q == PAT_CROSS));

endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, stby = 1'b0, ph = 1'b0, dir = 1'b1, gp = 1'b0, gn = 1'b0;
  logic ocp = 1'b0, otp = 1'b0;
  logic [2:0] mode = 3'b101;
  logic [1:0] dec = 2'b00;
  logic u1, u2, l1, l2, pump, hot;

  int checks = 0;
  int errors = 0;
  bit m_oc = 0, m_sp = 0;
  logic [3:0] e_g = 4'b0000;
  bit e_pump = 0, e_hot = 0;

  always #10 clk = ~clk;

  hbridge_gate_ctrl u_hbridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .standby_i(stby),
    .drive_mode_i(mode), .phase_mode_i(ph), .dir_pos_i(dir), .decay_i(dec),
    .gate_p_i(gp), .gate_n_i(gn), .ocp_det_i(ocp), .otp_det_i(otp),
    .u1_o(u1), .u2_o(u2), .l1_o(l1), .l2_o(l2), .pump_en_o(pump), .hot_flag_o(hot));

  wire [3:0] g = {u1, u2, l1, l2};

  task automatic compare(string tag);
    checks++;
    if (g !== e_g || pump !== e_pump || hot !== e_hot) begin
      errors++;
      $display("FAIL %s: gates=%b pump=%b hot=%b expected gates=%b pump=%b hot=%b",
               tag, g, pump, hot, e_g, e_pump, e_hot);
    end
    checks++;
    if ((u1 && l1) || (u2 && l2)) begin
      errors++;
      $display("FAIL R10 (%s): gates=%b expected no leg with both switches on", tag, g);
    end
  endtask

  task automatic tick(string tag);
    bit rise, halt;
    @(posedge clk);
    rise = stby && !m_sp;
    m_oc = ocp || (m_oc && !rise);
    m_sp = stby;
    halt = !stby || mode == 3'b000 || m_oc || otp;
    e_pump = !halt;
    e_hot = otp;
    if (halt || !en) e_g = 4'b0000;
    else if (ph) e_g = (gp && !gn) ? 4'b1001 : (!gp && gn) ? 4'b0110 : 4'b0000;
    else if (dec == 2'b00) e_g = dir ? 4'b1001 : 4'b0110;
    else if (dec == 2'b10) e_g = dir ? 4'b0110 : 4'b1001;
    else e_g = 4'b0011;
    #2;
    compare(tag);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    compare("R9 reset");
    @(posedge clk); #2;
    compare("R9 reset held");
    rst_n = 1'b1;
    stby = 1'b1; en = 1'b1; mode = 3'b101;
    tick("R9 first cycle");

    dir = 1'b1;
    for (int d = 0; d < 4; d++) begin dec = d[1:0]; tick("R1 positive"); end
    dir = 1'b0;
    for (int d = 0; d < 4; d++) begin dec = d[1:0]; tick("R2 negative"); end

    dec = 2'b00; dir = 1'b1; tick("R1");
    en = 1'b0; tick("R3 enable low");
    tick("R3 enable held low");
    en = 1'b1; tick("R3 enable back");
    tick("R9 latency");

    ph = 1'b1;
    for (int k = 0; k < 4; k++) begin
      {gp, gn} = k[1:0];
      dir = k[0]; dec = k[1:0];
      tick("R4 external drive");
    end
    gp = 1'b1; gn = 1'b0;
    for (int d = 0; d < 4; d++) begin dec = d[1:0]; dir = ~dir; tick("R4 decay ignored"); end
    ph = 1'b0; dec = 2'b10; dir = 1'b1; tick("R1 leave external");

    stby = 1'b0; tick("R5 standby low");
    tick("R5 standby held");
    stby = 1'b1; tick("R5 standby back");

    mode = 3'b000; tick("R6 mode zero");
    mode = 3'b001; tick("R6 nonzero mode");
    mode = 3'b111; tick("R6 nonzero mode");

    ocp = 1'b1; tick("R7 trip");
    ocp = 1'b0; tick("R7 latched");
    tick("R7 latched");
    en = 1'b0; tick("R7 enable low");
    en = 1'b1; tick("R7 enable does not clear");
    mode = 3'b000; tick("R7 mode zero");
    mode = 3'b110; tick("R7 mode does not clear");
    stby = 1'b0; ocp = 1'b1; tick("R7 standby low");
    stby = 1'b1; tick("R7 rise with detector high");
    ocp = 1'b0; tick("R7 still latched");
    stby = 1'b0; tick("R7 standby low again");
    stby = 1'b1; tick("R7 cleared on rise");
    tick("R7 running");

    otp = 1'b1; tick("R8 thermal");
    tick("R8 thermal held");
    otp = 1'b0; tick("R8 thermal released");

    for (int n = 0; n < 600; n++) begin
      en   = ($urandom % 8) != 0;
      stby = ($urandom % 10) != 0;
      mode = ($urandom % 6 == 0) ? 3'b000 : 3'($urandom);
      ph   = ($urandom % 4) == 0;
      dir  = 1'($urandom);
      dec  = 2'($urandom);
      gp   = 1'($urandom);
      gn   = 1'($urandom);
      ocp  = ($urandom % 25) == 0;
      otp  = ($urandom % 20) == 0;
      tick("R1 R2 R4 R7 R8 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule